// File: doc/BRIEF.md
# I2C Serial Clock Timing Generator

This block derives the I2C serial clock (SCL) from a fast functional clock. A programmable prescaler turns the functional clock into a slower internal tick. The lengths of the SCL low and high phases are counted in ticks. Each length comes from a register field plus a fixed bias: seven ticks are added to the low field and five to the high field. With these biases, software can centre the duty cycle near 50 %, and the low phase can come out one tick longer than the high phase when the period is odd.

Each of the two 16-bit timing registers holds two fields. The lower byte serves standard and fast mode. The upper byte serves the second phase of a high-speed transfer. When high-speed mode is selected, the generator first runs on the fast fields, because the opening phase of such a transfer must stay at or below 400 kHz. After software pulses a phase-switch strobe, the generator moves to the high-speed fields. Every timing change, including this switch, is applied at the start of a low phase, so the output never carries a shortened pulse. A one-cycle marker accompanies every falling and every rising SCL edge, so that a data shifter can align to the clock.

Top module: `i2c_scl_gen`

## Requirements
- R1: Every phase length scales with the prescaler: one tick lasts (prescale + 1) functional-clock cycles.
- R2: An SCL low phase lasts exactly (low field + 7) ticks.
- R3: An SCL high phase lasts exactly (high field + 5) ticks.
- R4: In each timing register, bits [7:0] hold the standard/fast field and bits [15:8] hold the high-speed field. Without high-speed operation, only bits [7:0] are used.
- R5: When high-speed mode is selected, the generator starts on the fast fields. After a one-cycle phase-switch strobe, the high-speed fields apply from the next low phase onward.
- R6: A phase-switch strobe has no effect while high-speed mode is deselected.
- R7: While reset is active or enable is low, SCL is held high and neither edge marker fires.
- R8: Prescaler and field values are captured when a low phase begins. Changing them mid-period alters neither the current low phase nor the high phase that follows it.
- R9: scl_fall is high for exactly the first cycle in which SCL is low, and scl_rise is high for exactly the first cycle in which SCL is high. This includes the return to high when enable drops during a low phase.
- R10: In the cycle after enable is first sampled high, SCL goes low and a new low phase begins.
- R11: When high-speed mode is deselected after a phase switch, the fast fields apply again from the next low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator when high; holds SCL high when low |
| prescale | input | 8 | Tick divider; one tick lasts prescale+1 cycles |
| low_cfg | input | 16 | Low-phase fields: [15:8] high-speed, [7:0] standard/fast |
| high_cfg | input | 16 | High-phase fields: [15:8] high-speed, [7:0] standard/fast |
| hs_mode | input | 1 | Selects high-speed operation |
| phase_switch | input | 1 | One-cycle strobe that moves to the high-speed fields |
| scl | output | 1 | Generated serial clock |
| scl_fall | output | 1 | One-cycle marker of a falling SCL edge |
| scl_rise | output | 1 | One-cycle marker of a rising SCL edge |

## Verification
The duration checks assume that enable stays high for a whole low or high phase before it is judged. The minimum-length properties therefore skip any edge that follows enable having been low within the previous two cycles. The stimulus keeps enable steady while durations are measured, and it drops enable only between measured windows or in the one directed case that cuts a low phase short. Phase-switch strobes and mid-period register writes are always driven while a phase is already in progress, so the latching point at the next low phase stays unambiguous.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } scl_phase_e;

   // Width able to hold the largest field value plus the larger bias.
   function automatic int len_bits(input int field_w, input int bias);
      return $clog2((2 ** field_w) + bias);
   endfunction

endpackage

// File: rtl/scl_tick_gen.sv
module scl_tick_gen #(
   parameter int PSC_W       = 8,
   parameter bit PRESCALE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PSC_W-1:0] div,
   output logic             tick
);

   if (PRESCALE_EN) begin : g_div
      logic [PSC_W-1:0] pc;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pc <= '0;
         end else if (!run || pc == div) begin
            pc <= '0;
         end else begin
            pc <= pc + PSC_W'(1);
         end
      end

      assign tick = run && (pc == div);
   end else begin : g_nodiv
      logic unused_div;
      assign unused_div = ^div;
      assign tick       = run;
   end

endmodule

// File: rtl/scl_field_pick.sv
module scl_field_pick #(
   parameter int FIELD_W   = 8,
   parameter int LEN_W     = 9,
   parameter int LOW_BIAS  = 7,
   parameter int HIGH_BIAS = 5
) (
   input  logic [2*FIELD_W-1:0] low_cfg,
   input  logic [2*FIELD_W-1:0] high_cfg,
   input  logic                 use_hs,
   output logic [LEN_W-1:0]     low_len,
   output logic [LEN_W-1:0]     high_len
);

   // Slot 0: standard/fast field, slot 1: high-speed field (R4)
   logic [FIELD_W-1:0] lo_f [2];
   logic [FIELD_W-1:0] hi_f [2];

   for (genvar g = 0; g < 2; g++) begin : g_slice
      assign lo_f[g] = low_cfg [g*FIELD_W +: FIELD_W];
      assign hi_f[g] = high_cfg[g*FIELD_W +: FIELD_W];
   end

   assign low_len  = LEN_W'(lo_f[use_hs]) + LEN_W'(LOW_BIAS);
   assign high_len = LEN_W'(hi_f[use_hs]) + LEN_W'(HIGH_BIAS);

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
   import scl_gen_pkg::*;
#(
   parameter int PSC_W = 8,
   parameter int LEN_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             tick,
   input  logic [PSC_W-1:0] new_psc,
   input  logic [LEN_W-1:0] new_low,
   input  logic [LEN_W-1:0] new_high,
   output logic             running,
   output logic [PSC_W-1:0] lat_psc,
   output logic             scl,
   output logic             scl_fall,
   output logic             scl_rise
);

   scl_phase_e       ph;
   logic [LEN_W-1:0] tc;
   logic [LEN_W-1:0] lat_low;
   logic [LEN_W-1:0] lat_high;
   logic             low_done;
   logic             high_done;

   assign low_done  = tick && (tc == lat_low  - LEN_W'(1));
   assign high_done = tick && (tc == lat_high - LEN_W'(1));
   assign running   = (ph != PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= PH_IDLE;
         tc       <= '0;
         lat_psc  <= '0;
         lat_low  <= '0;
         lat_high <= '0;
         scl      <= 1'b1;
         scl_fall <= 1'b0;
         scl_rise <= 1'b0;
      end else begin
         scl_fall <= 1'b0;
         scl_rise <= 1'b0;
         if (!enable) begin
            ph       <= PH_IDLE;
            tc       <= '0;
            scl      <= 1'b1;
            scl_rise <= ~scl;
         end else begin
            unique case (ph)
               PH_IDLE: begin
                  ph       <= PH_LOW;
                  tc       <= '0;
                  scl      <= 1'b0;
                  scl_fall <= 1'b1;
                  lat_psc  <= new_psc;
                  lat_low  <= new_low;
                  lat_high <= new_high;
               end
               PH_LOW: begin
                  if (low_done) begin
                     ph       <= PH_HIGH;
                     tc       <= '0;
                     scl      <= 1'b1;
                     scl_rise <= 1'b1;
                  end else if (tick) begin
                     tc <= tc + LEN_W'(1);
                  end
               end
               PH_HIGH: begin
                  if (high_done) begin
                     ph       <= PH_LOW;
                     tc       <= '0;
                     scl      <= 1'b0;
                     scl_fall <= 1'b1;
                     lat_psc  <= new_psc;
                     lat_low  <= new_low;
                     lat_high <= new_high;
                  end else if (tick) begin
                     tc <= tc + LEN_W'(1);
                  end
               end
               default: begin
                  ph  <= PH_IDLE;
                  scl <= 1'b1;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen #(
   parameter int PSC_W       = 8,
   parameter int FIELD_W     = 8,
   parameter int LOW_BIAS    = 7,
   parameter int HIGH_BIAS   = 5,
   parameter bit PRESCALE_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 enable,
   input  logic [PSC_W-1:0]     prescale,
   input  logic [2*FIELD_W-1:0] low_cfg,
   input  logic [2*FIELD_W-1:0] high_cfg,
   input  logic                 hs_mode,
   input  logic                 phase_switch,
   output logic                 scl,
   output logic                 scl_fall,
   output logic                 scl_rise
);

   localparam int MAX_BIAS = (LOW_BIAS > HIGH_BIAS) ? LOW_BIAS : HIGH_BIAS;
   localparam int LEN_W    = scl_gen_pkg::len_bits(FIELD_W, MAX_BIAS);

   if (PSC_W < 1) begin : g_bad_psc
      $error("PSC_W must be at least 1");
   end
   if (FIELD_W < 1) begin : g_bad_field
      $error("FIELD_W must be at least 1");
   end
   if (LOW_BIAS < 1 || HIGH_BIAS < 1) begin : g_bad_bias
      $error("phase biases must be at least 1");
   end

   logic             hs_sel;
   logic             tick;
   logic             running;
   logic [PSC_W-1:0] lat_psc;
   logic [LEN_W-1:0] low_len;
   logic [LEN_W-1:0] high_len;

   // Second-phase tracker: set by the strobe, cleared on leaving HS or disable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_sel <= 1'b0;
      end else if (!enable || !hs_mode) begin
         hs_sel <= 1'b0;
      end else if (phase_switch) begin
         hs_sel <= 1'b1;
      end
   end

   scl_field_pick #(
      .FIELD_W  (FIELD_W),
      .LEN_W    (LEN_W),
      .LOW_BIAS (LOW_BIAS),
      .HIGH_BIAS(HIGH_BIAS)
   ) u_pick (
      .low_cfg (low_cfg),
      .high_cfg(high_cfg),
      .use_hs  (hs_sel),
      .low_len (low_len),
      .high_len(high_len)
   );

   scl_tick_gen #(
      .PSC_W      (PSC_W),
      .PRESCALE_EN(PRESCALE_EN)
   ) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (running),
      .div  (lat_psc),
      .tick (tick)
   );

   scl_phase_seq #(
      .PSC_W(PSC_W),
      .LEN_W(LEN_W)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (enable),
      .tick    (tick),
      .new_psc (prescale),
      .new_low (low_len),
      .new_high(high_len),
      .running (running),
      .lat_psc (lat_psc),
      .scl     (scl),
      .scl_fall(scl_fall),
      .scl_rise(scl_rise)
   );

endmodule

// File: rtl/i2c_scl_gen_checks.sv
module i2c_scl_gen_checks #(
   parameter int LOW_BIAS  = 7,
   parameter int HIGH_BIAS = 5
) (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic scl,
   input logic scl_fall,
   input logic scl_rise
);

   int unsigned low_cnt;
   int unsigned high_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt  <= 0;
         high_cnt <= 0;
      end else begin
         low_cnt  <= scl ? 0 : low_cnt + 1;
         high_cnt <= scl ? high_cnt + 1 : 0;
      end
   end

   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (scl && !scl_fall)) else $error("idle not high"); // R7

   AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(enable) |=> (!scl && scl_fall)) else $error("no start"); // R10

   AST_FALL_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl) |-> scl_fall) else $error("unmarked fall"); // R9

   AST_RISE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl) |-> scl_rise) else $error("unmarked rise"); // R9

   AST_FALL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      scl_fall |-> (!scl && !scl_rise)) else $error("stray fall mark"); // R9

   AST_RISE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      scl_rise |-> scl) else $error("stray rise mark"); // R9

   AST_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(scl) && $past(enable)) |-> (low_cnt >= LOW_BIAS))
      else $error("low phase too short"); // R2

   AST_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(scl) && $past(enable) && $past(enable, 2)) |-> (high_cnt >= HIGH_BIAS))
      else $error("high phase too short"); // R3

endmodule

bind i2c_scl_gen i2c_scl_gen_checks #(
   .LOW_BIAS (LOW_BIAS),
   .HIGH_BIAS(HIGH_BIAS)
) u_checks (
   .clk     (clk),
   .rst_n   (rst_n),
   .enable  (enable),
   .scl     (scl),
   .scl_fall(scl_fall),
   .scl_rise(scl_rise)
);

// File: tb/i2c_scl_gen_test.sv
module i2c_scl_gen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [7:0]  prescale = '0;
   logic [15:0] low_cfg = '0;
   logic [15:0] high_cfg = '0;
   logic        hs_mode = 1'b0;
   logic        phase_switch = 1'b0;
   logic        scl, scl_fall, scl_rise;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   int lows[$];
   int highs[$];
   bit mon_on = 1'b0;
   int cnt = 0;
   bit have = 1'b0;
   bit lvl = 1'b0;

   always #10 clk = ~clk;

   i2c_scl_gen uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .prescale(prescale),
      .low_cfg(low_cfg), .high_cfg(high_cfg), .hs_mode(hs_mode),
      .phase_switch(phase_switch), .scl(scl), .scl_fall(scl_fall),
      .scl_rise(scl_rise)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_low(input int psc, input int f);
      return (psc + 1) * (f + 7);
   endfunction

   function automatic int exp_high(input int psc, input int f);
      return (psc + 1) * (f + 5);
   endfunction

   // Duration monitor: counts negedge samples of each SCL level
   always @(negedge clk) begin
      if (!mon_on) begin
         cnt  = 0;
         have = 1'b0;
      end else if (scl_fall) begin
         chk(scl == 1'b0, "R9 fall marker level", int'(scl), 0);
         if (have && lvl) highs.push_back(cnt);
         cnt = 1; lvl = 1'b0; have = 1'b1;
      end else if (scl_rise) begin
         chk(scl == 1'b1, "R9 rise marker level", int'(scl), 1);
         if (have && !lvl) lows.push_back(cnt);
         cnt = 1; lvl = 1'b1; have = 1'b1;
      end else begin
         cnt++;
      end
   end

   task automatic run_until(input int nl, input int nh);
      int guard = 0;
      while ((lows.size() < nl || highs.size() < nh) && guard < 20000) begin
         @(negedge clk);
         guard++;
      end
      if (guard >= 20000) chk(1'b0, "R2 phases did not complete", lows.size(), nl);
   endtask

   task automatic restart(input int psc, input int lof, input int hif,
                          input int lohs, input int hihs, input bit hsm);
      @(negedge clk);
      enable = 1'b0;
      mon_on <= 1'b0;
      repeat (3) @(negedge clk);
      chk(scl == 1'b1 && !scl_fall && !scl_rise, "R7 disabled holds high", int'(scl), 1);
      lows.delete();
      highs.delete();
      prescale = 8'(psc);
      low_cfg  = {8'(lohs), 8'(lof)};
      high_cfg = {8'(hihs), 8'(hif)};
      hs_mode  = hsm;
      mon_on  <= 1'b1;
      enable   = 1'b1;
      @(negedge clk);
      chk(scl == 1'b0 && scl_fall, "R10 low phase starts next cycle", int'(scl), 0);
   endtask

   initial begin
      int tmp;
      tmp = $urandom(32'd2024);
      // Reset state
      repeat (3) @(negedge clk);
      chk(scl == 1'b1 && !scl_fall && !scl_rise, "R7 reset holds high", int'(scl), 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(scl == 1'b1, "R7 idle after reset", int'(scl), 1);

      // Minimum fields, no prescale
      restart(0, 0, 0, 9, 9, 1'b0);
      run_until(2, 2);
      chk(lows[0] == 7, "R2 minimum low", lows[0], 7);
      chk(highs[0] == 5, "R3 minimum high", highs[0], 5);

      // Large prescaler
      restart(9, 1, 1, 0, 0, 1'b0);
      run_until(2, 2);
      chk(lows[1] == 80, "R1 prescaled low", lows[1], 80);
      chk(highs[1] == 60, "R1 prescaled high", highs[1], 60);

      // Randomized fast/standard settings; upper bytes differ (R4)
      for (int i = 0; i < 24; i++) begin
         int psc, lf, hf, lh, hh;
         bit hm;
         psc = int'($urandom_range(0, 3));
         lf  = int'($urandom_range(0, 20));
         hf  = int'($urandom_range(0, 20));
         lh  = int'($urandom_range(0, 255));
         hh  = int'($urandom_range(0, 255));
         hm  = 1'($urandom_range(0, 1));
         restart(psc, lf, hf, lh, hh, hm);
         run_until(2, 2);
         for (int k = 0; k < 2; k++) begin
            chk(lows[k] == exp_low(psc, lf), "R2 R4 random low", lows[k], exp_low(psc, lf));
            chk(highs[k] == exp_high(psc, hf), "R3 R4 random high", highs[k], exp_high(psc, hf));
         end
      end

      // High-speed switch sequence
      restart(1, 10, 9, 3, 2, 1'b1);
      run_until(1, 0);
      @(negedge clk);
      phase_switch = 1'b1;
      @(negedge clk);
      phase_switch = 1'b0;
      run_until(3, 3);
      chk(lows[0] == 34, "R5 first phase fast low", lows[0], 34);
      chk(highs[0] == 28, "R5 first phase fast high", highs[0], 28);
      chk(lows[1] == 20, "R5 hs low after switch", lows[1], 20);
      chk(highs[1] == 14, "R5 hs high after switch", highs[1], 14);
      chk(lows[2] == 20, "R5 hs low kept", lows[2], 20);
      hs_mode = 1'b0;
      run_until(5, 5);
      chk(lows[3] == 20, "R8 current period keeps hs", lows[3], 20);
      chk(lows[4] == 34, "R11 back to fast low", lows[4], 34);
      chk(highs[4] == 28, "R11 back to fast high", highs[4], 28);

      // Strobe ignored without high-speed mode
      restart(0, 4, 4, 0, 0, 1'b0);
      run_until(1, 0);
      @(negedge clk);
      phase_switch = 1'b1;
      @(negedge clk);
      phase_switch = 1'b0;
      run_until(3, 3);
      chk(lows[1] == 11, "R6 strobe ignored low", lows[1], 11);
      chk(highs[2] == 9, "R6 strobe ignored high", highs[2], 9);

      // Mid-period writes wait for the next low phase
      restart(0, 20, 10, 0, 0, 1'b0);
      repeat (3) @(negedge clk);
      low_cfg  = 16'h0002;
      high_cfg = 16'h0001;
      prescale = 8'd1;
      run_until(2, 2);
      chk(lows[0] == 27, "R8 current low unchanged", lows[0], 27);
      chk(highs[0] == 15, "R8 following high unchanged", highs[0], 15);
      chk(lows[1] == 18, "R8 new low applied", lows[1], 18);
      chk(highs[1] == 12, "R8 new high applied", highs[1], 12);

      // Disable in the middle of a low phase
      restart(0, 30, 3, 0, 0, 1'b0);
      repeat (5) @(negedge clk);
      mon_on <= 1'b0;
      enable = 1'b0;
      @(negedge clk);
      chk(scl == 1'b1 && scl_rise, "R9 rise marked on disable", int'(scl_rise), 1);
      @(negedge clk);
      chk(!scl_rise && !scl_fall && scl, "R7 no markers while disabled", int'(scl_rise), 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule